// File: doc/BRIEF.md
# Full-Rate Bit-Serial Transpose FIR Filter

This block is a programmable finite impulse response filter in transpose form. Its samples arrive and its results leave one bit per clock. Input words are two's complement and arrive least significant bit first. They follow one another with no idle or padding bits, so a new word starts every `W_DATA` clocks. Each tap has its own two's complement coefficient, presented in parallel on a shared bus. A word uses the coefficient values present on its first bit clock, which allows the coefficients to be reprogrammed between words while the filter runs.

Each tap contains a serial-parallel multiply-accumulate unit. The partial sum from the tap above is not summed in a separate adder. It is fed into the next tap's multiplier in three ways:
- Its lowest `W_COEF` bits preload the accumulator when the new product starts.
- Its remaining low bits enter serially through the multiplier's sum input.
- Its upper word is added bit by bit while the high half of the new product is shifted out.

Every inter-tap store is a single `W_DATA`-bit delay line per stream. The result is kept at full precision and leaves on two serial pins: the lower word on one pin and the upper word, sign-extended, on the other pin one word later.

Top module: `serial_fir`

## Requirements
- R1: The first rising clock edge after `rst` falls samples bit 0 of input word 0. Each later edge samples the next bit, and word n bit j is sampled at edge n·`W_DATA`+j, with no gaps between words.
- R2: After the edge that samples bit j of word n, `yLow` carries bit j of y(n) (bits 0 to `W_DATA`-1 of the result, LSB first).
- R3: After the edge that samples bit j of word n+1, `yHigh` carries bit j of y(n) >> `W_DATA` (arithmetic shift), sign-extended to `W_DATA` bits.
- R4: The full result is y(n) = Σᵢ cᵢ(n−i)·x(n−i) over the taps i = 0..`N_TAPS`-1, where cᵢ(n) is tap i's coefficient in force for word n. The upper and lower words together reproduce y(n) exactly as a `W_DATA`+`W_COEF`+clog2(`N_TAPS`) bit signed value.
- R5: Tap i's coefficient is taken from `coefs[i*W_COEF +: W_COEF]` on the first bit clock of each word. Values on the bus at any other clock of that word have no effect on any output.
- R6: Reset clears all history. Results behave as if all earlier inputs were zero, and `yHigh` stays 0 throughout the first word after reset.
- R7: The most negative input combined with the most negative or most positive coefficients on every tap gives the exact result, with no wrap.
- R8: The internal word-start and word-end strobes never coincide. A word-end strobe is always followed on the next clock by a word-start strobe, and the sum-input enable is off on a word-start clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| xBit | input | 1 | Serial input sample bit, LSB first |
| coefs | input | N_TAPS*W_COEF | Packed tap coefficients, tap i in slice i |
| yLow | output | 1 | Serial lower word of the result |
| yHigh | output | 1 | Serial upper word of the result, one word later |

## Verification
The hardest cases to reach from the pins are the accumulation carries that cross from the lower word into the upper word. These appear only when several taps add large products of the same sign, and the preloaded low bits of the upstream sum push the product past a word boundary. The stimulus opens with runs of the most negative sample against extreme coefficients on every tap, so that all three taps sum at once near full scale. Long random back-to-back words follow. During those words the coefficient bus changes to unrelated values on every clock except each word's first bit, so any leak of mid-word coefficients shows up in the reconstructed result.

// File: rtl/bsfir_pkg.sv
package bsfir_pkg;

  // Strobes broadcast from the word sequencer to every tap.
  typedef struct packed {
    logic first;   // bit 0 of a word: preload accumulator, restart serial adder
    logic last;    // final bit: negate sign partial product, download high half
    logic sumEn;   // upstream low bits enter the free sum input
  } strobe_t;

endpackage

// File: rtl/bsfir_ctrl.sv
module bsfir_ctrl
  import bsfir_pkg::*;
#(
  parameter int W_DATA = 16,
  parameter int W_COEF = 12
) (
  input  logic    clk,
  input  logic    rst,
  output strobe_t strobe
);

  localparam int CW = (W_DATA > 1) ? $clog2(W_DATA) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(W_DATA - 1);
  localparam logic [CW-1:0] SUM_IDX  = CW'(W_COEF);

  logic [CW-1:0] bitIdx;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      bitIdx <= '0;
    end else if (bitIdx == LAST_IDX) begin
      bitIdx <= '0;
    end else begin
      bitIdx <= bitIdx + 1'b1;
    end
  end

  assign strobe.first = (bitIdx == '0);
  assign strobe.last  = (bitIdx == LAST_IDX);
  assign strobe.sumEn = (bitIdx >= SUM_IDX);

endmodule

// File: rtl/bsfir_tap.sv
module bsfir_tap
  import bsfir_pkg::*;
#(
  parameter int W_DATA = 16,
  parameter int W_COEF = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  strobe_t                  strobe,
  input  logic                     xBit,
  input  logic signed [W_COEF-1:0] coef,
  input  logic [W_DATA-1:0]        upLow,    // upstream low stream, delayed one word
  input  logic [W_DATA-1:0]        upHigh,   // upstream high stream, delayed one word
  output logic [W_DATA-1:0]        lowHist,  // own low stream, delay line
  output logic [W_DATA-1:0]        highHist  // own high stream, delay line
);

  localparam int AW = W_COEF + 2;

  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] accIn;
  logic signed [AW-1:0] coefExt;
  logic signed [AW-1:0] partial;
  logic signed [AW-1:0] addIn;
  logic signed [AW-1:0] sum;
  logic signed [AW-1:0] hiPart;
  logic [W_DATA-1:0]    highLoad;
  logic [W_DATA-1:0]    highShift;
  logic                 carry;
  logic                 carryIn;
  logic                 lowBit;
  logic                 highBit;

  // Multiply-accumulate: the oldest upstream low bits seed the accumulator,
  // later ones enter through the sum input.
  assign coefExt = {{2{coef[W_COEF-1]}}, coef};
  assign partial = xBit ? (strobe.last ? -coefExt : coefExt) : '0;
  assign accIn   = strobe.first ? signed'({2'b00, upLow[W_COEF-1:0]}) : acc;
  assign addIn   = signed'({{(AW-1){1'b0}}, strobe.sumEn & upLow[0]});
  assign sum     = accIn + partial + addIn;
  assign lowBit  = sum[0];
  assign hiPart  = sum >>> 1;
  assign highLoad = {{(W_DATA-AW){hiPart[AW-1]}}, hiPart};

  // Serial adder merging own high half with the upstream high stream.
  assign carryIn = strobe.first ? 1'b0 : carry;
  assign highBit = highShift[0] ^ upHigh[0] ^ carryIn;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      acc       <= '0;
      highShift <= '0;
      carry     <= 1'b0;
      lowHist   <= '0;
      highHist  <= '0;
    end else begin
      acc       <= hiPart;
      highShift <= strobe.last ? highLoad : {1'b0, highShift[W_DATA-1:1]};
      carry     <= (highShift[0] & upHigh[0]) | (highShift[0] & carryIn) |
                   (upHigh[0] & carryIn);
      lowHist   <= {lowBit, lowHist[W_DATA-1:1]};
      highHist  <= {highBit, highHist[W_DATA-1:1]};
    end
  end

endmodule

// File: rtl/bsfir_datapath.sv
module bsfir_datapath
  import bsfir_pkg::*;
#(
  parameter int W_DATA = 16,
  parameter int W_COEF = 12,
  parameter int N_TAPS = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  strobe_t                    strobe,
  input  logic                       xBit,
  input  logic [N_TAPS*W_COEF-1:0]   coefs,
  output logic                       yLow,
  output logic                       yHigh
);

  logic [W_DATA-1:0] lowHist  [N_TAPS+1];
  logic [W_DATA-1:0] highHist [N_TAPS+1];

  // Nothing enters above the last tap.
  assign lowHist[N_TAPS]  = '0;
  assign highHist[N_TAPS] = '0;

  for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
    logic signed [W_COEF-1:0] coefReg;
    logic signed [W_COEF-1:0] coefNow;

    // The coefficient on the bus at bit 0 governs the whole word.
    assign coefNow = strobe.first ? coefs[t*W_COEF +: W_COEF] : coefReg;

    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        coefReg <= '0;
      end else if (strobe.first) begin
        coefReg <= coefs[t*W_COEF +: W_COEF];
      end
    end

    bsfir_tap #(
      .W_DATA(W_DATA),
      .W_COEF(W_COEF)
    ) u_tap (
      .clk     (clk),
      .rst     (rst),
      .strobe  (strobe),
      .xBit    (xBit),
      .coef    (coefNow),
      .upLow   (lowHist[t+1]),
      .upHigh  (highHist[t+1]),
      .lowHist (lowHist[t]),
      .highHist(highHist[t])
    );
  end

  // The newest bit of tap 0's delay lines is the registered filter output.
  assign yLow  = lowHist[0][W_DATA-1];
  assign yHigh = highHist[0][W_DATA-1];

endmodule

// File: rtl/serial_fir.sv
module serial_fir
  import bsfir_pkg::*;
#(
  parameter int W_DATA = 16,
  parameter int W_COEF = 12,
  parameter int N_TAPS = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     xBit,
  input  logic [N_TAPS*W_COEF-1:0] coefs,
  output logic                     yLow,
  output logic                     yHigh
);

  strobe_t strobe;

  bsfir_ctrl #(
    .W_DATA(W_DATA),
    .W_COEF(W_COEF)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe)
  );

  bsfir_datapath #(
    .W_DATA(W_DATA),
    .W_COEF(W_COEF),
    .N_TAPS(N_TAPS)
  ) u_datapath (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .xBit  (xBit),
    .coefs (coefs),
    .yLow  (yLow),
    .yHigh (yHigh)
  );

endmodule

// File: rtl/bsfir_checker.sv
module bsfir_checker #(
  parameter int W_DATA = 16
) (
  input logic clk,
  input logic rst,
  input logic first,
  input logic last,
  input logic sumEn,
  input logic yHigh
);

  localparam int CW = $clog2(W_DATA + 2);

  logic [CW-1:0] sinceReset;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sinceReset <= '0;
    end else if (sinceReset <= CW'(W_DATA)) begin
      sinceReset <= sinceReset + 1'b1;
    end
  end

  assert_last_then_first_R8: assert property (
    @(posedge clk) disable iff (rst) last |=> first);

  assert_strobe_exclusive_R8: assert property (
    @(posedge clk) disable iff (rst) $onehot0({first, last}));

  assert_sum_off_at_first_R8: assert property (
    @(posedge clk) disable iff (rst) first |-> !sumEn);

  assert_high_quiet_R6: assert property (
    @(posedge clk) disable iff (rst) (sinceReset <= CW'(W_DATA)) |-> !yHigh);

endmodule

bind serial_fir bsfir_checker #(
  .W_DATA(W_DATA)
) u_bsfirChecker (
  .clk  (clk),
  .rst  (rst),
  .first(strobe.first),
  .last (strobe.last),
  .sumEn(strobe.sumEn),
  .yHigh(yHigh)
);

// File: tb/test_serial_fir.sv
module test_serial_fir;

  localparam int W  = 16;
  localparam int M  = 12;
  localparam int K  = 3;
  localparam int NW = 160;
  localparam int N_DIRECTED = 14;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             xBit = 1'b0;
  logic [K*M-1:0]   coefs = '0;
  logic             yLow;
  logic             yHigh;

  int testsRun = 0;
  int testsFailed = 0;

  logic signed [W-1:0] xWord  [NW];
  logic signed [M-1:0] coefAt [NW][K];
  logic [W-1:0]        lowBuf;
  logic [W-1:0]        highBuf;
  logic [W-1:0]        lowSaved;

  always #5 clk = ~clk;

  serial_fir #(.W_DATA(W), .W_COEF(M), .N_TAPS(K)) i_serial_fir (
    .clk(clk), .rst(rst), .xBit(xBit), .coefs(coefs), .yLow(yLow), .yHigh(yHigh)
  );

  // Transpose recurrence unrolled: y(n) = sum_i c_i(n-i) * x(n-i)  (R4)
  function automatic longint expY(int n);
    longint e = 0;
    for (int i = 0; i < K; i++) begin
      if (n - i >= 0) e += longint'(coefAt[n-i][i]) * longint'(xWord[n-i]);
    end
    return e;
  endfunction

  task automatic check(string req, longint act, longint exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(int g);
    int n = g / W;
    int j = g % W;
    logic [K*M-1:0] v;
    xBit = xWord[n][j];
    if (j == 0) begin
      for (int i = 0; i < K; i++) v[i*M +: M] = coefAt[n][i];
      coefs = v;
    end else begin
      // Mid-word bus noise must be ignored (R5)
      coefs = {$urandom, $urandom};
    end
  endtask

  task automatic sample(int g);
    int n = g / W;
    int j = g % W;
    longint e;
    longint full;
    lowBuf[j]  = yLow;
    highBuf[j] = yHigh;
    if (j == W - 1) begin
      e = expY(n);
      check((n == 0) ? "R1" : ((n >= N_DIRECTED) ? "R5" : "R2"),
            longint'(lowBuf), longint'(e[W-1:0]));
      if (n == 0) begin
        check("R6", longint'(highBuf), 0);
      end else begin
        e = expY(n - 1);
        check("R3", longint'(highBuf), longint'(e[2*W-1:W]));
        full = (longint'($signed(highBuf)) <<< W) + longint'(lowSaved);
        check((n - 1 < N_DIRECTED) ? "R7" : "R4", full, e);
      end
      lowSaved = lowBuf;
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int n = 0; n < NW; n++) begin
      if (n < 6) begin
        xWord[n] = 16'sh8000;
        for (int i = 0; i < K; i++) coefAt[n][i] = -12'sd2048;
      end else if (n < 10) begin
        xWord[n] = 16'sh8000;
        for (int i = 0; i < K; i++) coefAt[n][i] = 12'sd2047;
      end else if (n < N_DIRECTED) begin
        xWord[n] = (n == 12) ? 16'sh7FFF : 16'sh0000;
        for (int i = 0; i < K; i++) coefAt[n][i] = -12'sd2048;
      end else begin
        xWord[n] = W'($urandom);
        for (int i = 0; i < K; i++) coefAt[n][i] = M'($urandom);
      end
    end

    repeat (3) @(negedge clk);
    // Outputs cleared during reset (R6)
    check("R6", longint'({yLow, yHigh}), 0);
    rst = 1'b0;
    drive(0);
    for (int g = 0; g < NW * W; g++) begin
      @(negedge clk);
      sample(g);
      if (g + 1 < NW * W) drive(g + 1);
    end
    // Strobe ordering (R8) is watched by the bound checker throughout.
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(10 * 200000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule